// File: doc/BRIEF.md
# Prescaled 64-bit Wakeup Timer

This block keeps a 64-bit running count on the always-on clock and raises a wakeup when that count reaches a programmed 64-bit limit. A 12-bit divider sets the rate: the count moves up by one after every (divider + 1) clock cycles, and only while counting is switched on. Software sets the limit and the count, and reads them back, as pairs of 32-bit words.

On expiry the block sets an interrupt flag, which software clears by writing 1, and a separate wakeup-cause flag, which software clears only by writing 0. The wakeup-cause flag drives the request line that goes to the power controller. A test register lets software force the interrupt flag. Bus adapters and any clock crossing sit outside this block. The register port is a plain single-cycle write strobe with a combinational read mux.

Top module: `wake_timer`

## Requirements
- R1: While reset is held, every readable register returns 0 and both `irq_o` and `wake_req_o` are 0.
- R2: Byte offsets are CTRL 0x00, LIMIT_HI 0x08, LIMIT_LO 0x0C, COUNT_HI 0x10, COUNT_LO 0x14, FLAG 0x18, FORCE 0x1C, CAUSE 0x20. CTRL bit 0 is the run enable and bits 12:1 are the divider. Reserved bits are dropped on write and read as 0. FORCE and unmapped offsets read 0.
- R3: The count changes only while the run enable is 1. It then increments once every (divider + 1) cycles, with the first increment on the (divider + 1)-th cycle after enabling.
- R4: The divider phase restarts from zero while the run enable is 0 and on any write to either count word.
- R5: A write to COUNT_HI or COUNT_LO replaces only that 32-bit half, and it takes priority over an increment in the same cycle.
- R6: When count >= limit, FLAG bit 0 is 1 on the next cycle and `irq_o` follows FLAG bit 0.
- R7: Writing 1 to FLAG bit 0 clears it unless count >= limit in that cycle, in which case the flag stays set.
- R8: Writing 1 to FORCE bit 0 sets FLAG bit 0 on the next cycle.
- R9: CAUSE bit 0 sets when count >= limit. It is cleared only by writing 0 to bit 0, and writing 1 has no effect. `wake_req_o` equals CAUSE bit 0.
- R10: Both the increment and the comparison cover all 64 bits, including a carry out of the low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, one write per asserted cycle |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Wakeup-expired interrupt |
| wake_req_o | output | 1 | Wakeup request (cause flag) |

## Verification
The bench targets the cycle on which the first increment lands after enabling with a non-zero divider. A divider that is off by one shows up as a count read that leads or lags the expected value. It disables counting part-way through a period and writes the count part-way through a period; a phase that is not restarted makes the next increment arrive early. It clears the flag while the expiry condition still holds and writes 1 to the cause register, so a design that gives the clear priority, or treats cause as write-1-to-clear, drops a flag that must stay set. The count is started just below a 32-bit boundary with the limit just above it; a design that loses the carry or compares only the low word either never expires or expires too early.

// File: rtl/wt_pkg.sv
package wt_pkg;
    localparam int ADDR_W  = 6;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 64;
    localparam int DIV_W   = 12;

    localparam logic [ADDR_W-1:0] A_CTRL     = 6'h00;
    localparam logic [ADDR_W-1:0] A_LIMIT_HI = 6'h08;
    localparam logic [ADDR_W-1:0] A_LIMIT_LO = 6'h0C;
    localparam logic [ADDR_W-1:0] A_COUNT_HI = 6'h10;
    localparam logic [ADDR_W-1:0] A_COUNT_LO = 6'h14;
    localparam logic [ADDR_W-1:0] A_FLAG     = 6'h18;
    localparam logic [ADDR_W-1:0] A_FORCE    = 6'h1C;
    localparam logic [ADDR_W-1:0] A_CAUSE    = 6'h20;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] limit;
        logic             flag;
        logic             cause;
    } wt_regs_t;
endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_d, phase_q;

    always_comb begin
        tick_o  = run_i && (phase_q == div_i);
        phase_d = phase_q + 1'b1;
        if (!run_i || restart_i || tick_o) phase_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    // R3: no tick unless running
    p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);
    // R4: stopped phase is back at zero next cycle
    p_phase_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || restart_i) |=> (phase_q == '0));
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  count_o
);
    localparam int HI_W = CNT_W - WORD_W;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_hi_i)      cnt_d[CNT_W-1:WORD_W] = wdata_i[HI_W-1:0];
        else if (wr_lo_i) cnt_d[WORD_W-1:0]     = wdata_i;
        else if (tick_i)  cnt_d                 = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    // R3: count holds without a tick or a write
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_hi_i && !wr_lo_i) |=> $stable(cnt_q));
    // R10: a tick adds exactly one over the full width
    p_incr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_hi_i && !wr_lo_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R5: writing the low half leaves the high half alone
    p_lo_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_i && !wr_hi_i) |=> (cnt_q[CNT_W-1:WORD_W] == $past(cnt_q[CNT_W-1:WORD_W])));
endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              wake_req_o
);
    wt_regs_t         r_d, r_q;
    logic [CNT_W-1:0] count;
    logic             tick, hit;
    logic             wr_ctrl, wr_lim_hi, wr_lim_lo, wr_cnt_hi, wr_cnt_lo;
    logic             wr_flag, wr_force, wr_cause;

    always_comb begin
        wr_ctrl   = reg_we && (reg_addr == A_CTRL);
        wr_lim_hi = reg_we && (reg_addr == A_LIMIT_HI);
        wr_lim_lo = reg_we && (reg_addr == A_LIMIT_LO);
        wr_cnt_hi = reg_we && (reg_addr == A_COUNT_HI);
        wr_cnt_lo = reg_we && (reg_addr == A_COUNT_LO);
        wr_flag   = reg_we && (reg_addr == A_FLAG);
        wr_force  = reg_we && (reg_addr == A_FORCE);
        wr_cause  = reg_we && (reg_addr == A_CAUSE);
    end

    wt_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (r_q.ctrl.run),
        .restart_i (wr_cnt_hi || wr_cnt_lo),
        .div_i     (r_q.ctrl.div),
        .tick_o    (tick)
    );

    wt_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .wr_hi_i (wr_cnt_hi),
        .wr_lo_i (wr_cnt_lo),
        .wdata_i (reg_wdata),
        .count_o (count)
    );

    assign hit = (count >= r_q.limit);

    always_comb begin
        r_d = r_q;
        if (wr_ctrl)   r_d.ctrl = reg_wdata[DIV_W:0];
        if (wr_lim_hi) r_d.limit[CNT_W-1:WORD_W] = reg_wdata;
        if (wr_lim_lo) r_d.limit[WORD_W-1:0]     = reg_wdata;
        if (hit || (wr_force && reg_wdata[0])) r_d.flag = 1'b1;
        else if (wr_flag && reg_wdata[0])      r_d.flag = 1'b0;
        if (hit)                               r_d.cause = 1'b1;
        else if (wr_cause && !reg_wdata[0])    r_d.cause = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:     reg_rdata[DIV_W:0] = r_q.ctrl;
            A_LIMIT_HI: reg_rdata = r_q.limit[CNT_W-1:WORD_W];
            A_LIMIT_LO: reg_rdata = r_q.limit[WORD_W-1:0];
            A_COUNT_HI: reg_rdata = count[CNT_W-1:WORD_W];
            A_COUNT_LO: reg_rdata = count[WORD_W-1:0];
            A_FLAG:     reg_rdata[0] = r_q.flag;
            A_CAUSE:    reg_rdata[0] = r_q.cause;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_o      = r_q.flag;
    assign wake_req_o = r_q.cause;

    // R6/R7: expiry wins over a clear
    p_expiry_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq_o);
    // R8: forcing sets the flag
    p_force_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_force && reg_wdata[0]) |=> irq_o);
    // R9: cause drops only after a zero write
    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_o && !(wr_cause && !reg_wdata[0])) |=> wake_req_o);
    // R9: cause rises only on expiry
    p_cause_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_req_o && !hit) |=> !wake_req_o);
endmodule

// File: tb/sim_wake_timer.sv
`timescale 1ns/1ps
module sim_wake_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o, wake_req_o;

    always #2 clk = ~clk;

    wake_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .wake_req_o(wake_req_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    longint unsigned m_cnt, m_lim;
    bit  m_run, m_flag, m_cause;
    int  m_div, m_phase;

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00: return {19'd0, m_div[11:0], m_run};
            6'h08: return m_lim[63:32];
            6'h0C: return m_lim[31:0];
            6'h10: return m_cnt[63:32];
            6'h14: return m_cnt[31:0];
            6'h18: return {31'd0, m_flag};
            6'h20: return {31'd0, m_cause};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit w, input logic [5:0] a, input logic [31:0] d);
        bit hit, tick, cwr;
        longint unsigned nc;
        hit  = (m_cnt >= m_lim);
        cwr  = w && (a == 6'h10 || a == 6'h14);
        tick = m_run && (m_phase == m_div);
        nc   = m_cnt;
        if (w && a == 6'h10)      nc = {d, m_cnt[31:0]};
        else if (w && a == 6'h14) nc = {m_cnt[63:32], d};
        else if (tick)            nc = m_cnt + 1;
        if (!m_run || cwr || tick) m_phase = 0;
        else                       m_phase = (m_phase + 1) % 4096;
        if (hit || (w && a == 6'h1C && d[0]))  m_flag = 1;
        else if (w && a == 6'h18 && d[0])      m_flag = 0;
        if (hit)                               m_cause = 1;
        else if (w && a == 6'h20 && !d[0])     m_cause = 0;
        if (w && a == 6'h00) begin m_run = d[0]; m_div = int'(d[12:1]); end
        if (w && a == 6'h08) m_lim = {d, m_lim[31:0]};
        if (w && a == 6'h0C) m_lim = {m_lim[63:32], d};
        m_cnt = nc;
    endtask

    // one clock: drive at the falling edge, compare, advance the model
    task automatic cyc(input bit w, input logic [5:0] a, input logic [31:0] d);
        reg_we = w; reg_addr = a; reg_wdata = d;
        #1;
        check("rdata", reg_rdata, exp_rd(a));
        check("irq_o", {31'd0, irq_o}, {31'd0, m_flag});
        check("wake_req_o", {31'd0, wake_req_o}, {31'd0, m_cause});
        model_step(w, a, d);
        @(negedge clk);
    endtask

    task automatic rd(input logic [5:0] a, input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        m_cnt = 0; m_lim = 0; m_run = 0; m_flag = 0; m_cause = 0; m_div = 0; m_phase = 0;
        // R1: reset values
        cur_req = "R1";
        @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            reg_addr = 6'(i * 4);
            #0.5;
            check("reset rdata", reg_rdata, 32'd0);
            check("reset outputs", {30'd0, irq_o, wake_req_o}, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R6: limit 0 and count 0 already meet the condition
        cur_req = "R6";
        rd(6'h18, 3);
        // R7: clear refused while condition still holds
        cur_req = "R7";
        cyc(1, 6'h18, 32'h1);
        rd(6'h18, 2);
        // R10: move the limit out of reach, then clear works
        cur_req = "R10";
        cyc(1, 6'h08, 32'hFFFF_FFFF);
        rd(6'h08, 1);
        cur_req = "R7";
        cyc(1, 6'h18, 32'h1);
        rd(6'h18, 2);
        // R9: writing 1 to cause is ignored, writing 0 clears
        cur_req = "R9";
        cyc(1, 6'h20, 32'hFFFF_FFFF);
        rd(6'h20, 2);
        cyc(1, 6'h20, 32'hFFFF_FFFE);
        rd(6'h20, 2);
        // R2: reserved bits dropped, unmapped reads zero
        cur_req = "R2";
        cyc(1, 6'h00, 32'hFFFF_E006);
        rd(6'h00, 1);
        rd(6'h1C, 1);
        rd(6'h24, 1);
        cyc(1, 6'h1C, 32'hFFFF_FFFE);
        rd(6'h18, 1);
        // R3: divider 3, counting every fourth cycle
        cur_req = "R3";
        rd(6'h14, 3);
        cyc(1, 6'h00, 32'h7);
        rd(6'h14, 21);
        // R4: stop mid-period, restart phase
        cur_req = "R4";
        cyc(1, 6'h00, 32'h6);
        rd(6'h14, 3);
        cyc(1, 6'h00, 32'h7);
        rd(6'h14, 2);
        cyc(1, 6'h14, 32'd50);
        rd(6'h14, 9);
        // R5: count writes beat increments, halves independent
        cur_req = "R5";
        cyc(1, 6'h00, 32'h1);
        rd(6'h14, 2);
        cyc(1, 6'h14, 32'd100);
        rd(6'h14, 2);
        cyc(1, 6'h10, 32'h0000_0007);
        rd(6'h10, 1);
        rd(6'h14, 2);
        cyc(1, 6'h10, 32'h0);
        rd(6'h10, 1);
        // R10: carry across the word boundary reaches a 64-bit limit
        cur_req = "R10";
        cyc(1, 6'h00, 32'h0);
        cyc(1, 6'h08, 32'h1);
        cyc(1, 6'h0C, 32'h5);
        cyc(1, 6'h10, 32'h0);
        cyc(1, 6'h14, 32'hFFFF_FFF0);
        rd(6'h18, 2);
        cyc(1, 6'h00, 32'h1);
        for (int i = 0; i < 12; i++) begin rd(6'h10, 1); rd(6'h14, 1); end
        rd(6'h18, 6);
        rd(6'h20, 2);
        // R8: force with the condition false
        cur_req = "R8";
        cyc(1, 6'h00, 32'h0);
        cyc(1, 6'h08, 32'hFFFF_FFFF);
        cyc(1, 6'h18, 32'h1);
        rd(6'h18, 2);
        cyc(1, 6'h1C, 32'h1);
        rd(6'h18, 2);
        cyc(1, 6'h18, 32'h1);
        rd(6'h18, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule